// File: doc/BRIEF.md
# Precise Exception Commit Tracker

This block follows a short window of in-flight instructions in program order and decides when an exception tied to one of them may turn into an interrupt. Each window slot records its instruction's address and any exception marks it collects. A mark can come from three points: fetch, execute, or after completion. The block also decides which marks are thrown away. These are marks behind an older redirect, marks behind an older instruction that takes an interrupt first, and completion-time debug events on an instruction that already faulted.

Interrupt decisions are made only for the oldest slot, the head. A fetch mark waits there until the processor reports a recoverable state. An execute mark is acted on as soon as its instruction is the oldest, and that instruction is not retired. A completed instruction retires, and if it carries an enabled completion-time debug event, an interrupt is raised with the address of the following instruction. A data-address debug event that arrives together with a data translation or data storage fault gives an imprecise debug interrupt, reported on a status bit, with the address of the load or store. Every interrupt empties the window.

Top module: `exc_commit_tracker`

## Requirements
- R1: After reset, `take_valid`, `take_imp` and `retire_valid` are 0, `win_full` is 0 and `tail_slot` is 0.
- R2: Instructions retire strictly in allocation order. A completed instruction retires (`retire_valid`=1, `retire_pc`=its address) one cycle after it is both the oldest entry and marked complete. A completed younger entry never retires ahead of an incomplete older one.
- R3: A fetch-marked entry raises `take_valid` with `take_cause`=3'b000 and `take_pc`=its address one cycle after it is the oldest entry while `recov` is 1. While `recov` is 0 it waits and nothing is taken.
- R4: A redirect on slot `redirect_idx` removes every younger entry, fetch marks included, with no interrupt. `tail_slot` becomes `redirect_idx`+1 (mod depth).
- R5: An execute-marked entry is taken only once all older entries have retired. It gives `take_cause`={1'b1, class} and `take_pc`=its address, and `retire_valid` stays 0 (the entry is not completed). The class is 0 for program, 1 for system call, 2 for data TLB and 3 for data storage.
- R6: When an older instruction completes with an interrupt, a pending execute mark on a younger entry is discarded and never taken.
- R7: A completion-time debug event is taken only if it is enabled: `cmpl_post` bit 0 is data address compare, enabled by `dbg_en` bit 0, and bit 1 is instruction complete, enabled by `dbg_en` bit 1. It is taken in the same cycle the instruction retires, with `take_cause`=3'b001 and `take_pc`=address+4. A disabled event retires the entry with no interrupt.
- R8: An entry that has both an execute mark and a completion-time debug event gives only the execute interrupt.
- R9: An execute mark of class 2 or 3 with `exec_dac`=1 gives `take_cause`=3'b010 and `take_imp`=1, with `take_pc`=the faulting instruction's address. `take_imp` is 0 in all other cases.
- R10: Every interrupt flushes the whole window. In the cycle `take_valid` is 1, `tail_slot` is 0 and `win_full` is 0.
- R11: With four entries held, `win_full` is 1 and `alloc_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recov | input | 1 | Processor is in a recoverable state |
| dbg_en | input | 2 | Enables for the completion-time debug events (bit0 address compare, bit1 instruction complete) |
| alloc_valid | input | 1 | Append an instruction at `tail_slot` |
| alloc_pc | input | PCW | Address of the appended instruction |
| alloc_fexc | input | 1 | Appended instruction carries a fetch exception |
| exec_valid | input | 1 | Execute-stage exception mark |
| exec_idx | input | IDXW | Slot receiving the execute mark |
| exec_class | input | 2 | Execute exception class |
| exec_dac | input | 1 | Data address compare seen together with the execute exception |
| cmpl_valid | input | 1 | Instruction completed |
| cmpl_idx | input | IDXW | Slot that completed |
| cmpl_post | input | 2 | Completion-time debug events raised |
| redirect_valid | input | 1 | Redirect after the given slot |
| redirect_idx | input | IDXW | Slot that redirects |
| tail_slot | output | IDXW | Slot that the next allocation fills |
| win_full | output | 1 | Window holds all entries |
| take_valid | output | 1 | Interrupt taken this cycle |
| take_cause | output | 3 | Cause class of the interrupt |
| take_pc | output | PCW | Saved program counter |
| take_imp | output | 1 | Imprecise debug status |
| retire_valid | output | 1 | An instruction retired |
| retire_pc | output | PCW | Address of the retired instruction |

## Verification
The bound checker looks at every cycle for a few relations. Each interrupt must come with an emptied window. An execute interrupt must never come with a retirement. A completion-time debug interrupt must always come with one. A fetch interrupt must follow a cycle with `recov` high, and the imprecise bit must only appear with its own cause code. The directed scenarios are needed for the ordering properties, which no single cycle can show: a younger completion held behind an older one, a redirect that drops a fetch mark, an older debug event that discards a younger fault, a disabled event that retires quietly, and a full window that refuses a fifth instruction.

// File: rtl/exc_commit_tracker.sv
module exc_commit_tracker #(
  parameter int DEPTH = 4,
  parameter int PCW = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            recov,
  input  logic [1:0]      dbg_en,
  input  logic            alloc_valid,
  input  logic [PCW-1:0]  alloc_pc,
  input  logic            alloc_fexc,
  input  logic            exec_valid,
  input  logic [IDXW-1:0] exec_idx,
  input  logic [1:0]      exec_class,
  input  logic            exec_dac,
  input  logic            cmpl_valid,
  input  logic [IDXW-1:0] cmpl_idx,
  input  logic [1:0]      cmpl_post,
  input  logic            redirect_valid,
  input  logic [IDXW-1:0] redirect_idx,
  output logic [IDXW-1:0] tail_slot,
  output logic            win_full,
  output logic            take_valid,
  output logic [2:0]      take_cause,
  output logic [PCW-1:0]  take_pc,
  output logic            take_imp,
  output logic            retire_valid,
  output logic [PCW-1:0]  retire_pc
);
  logic [DEPTH-1:0] vld, fx, xx, dn, pe, dac;
  logic [1:0]       xc [DEPTH];
  logic [PCW-1:0]   pcs [DEPTH];
  logic [IDXW-1:0]  head;
  logic [IDXW:0]    cnt;

  logic hv, take_f, take_x, ret, take_p, take_any, imp, redir_ok, alloc_ok;
  logic [IDXW-1:0] off_r;
  logic [IDXW:0]   base_cnt;
  logic [2:0]      cause_n;

  assign tail_slot = head + cnt[IDXW-1:0];
  assign win_full  = (cnt == (IDXW+1)'(DEPTH));

  assign hv       = (cnt != '0) && vld[head];
  assign take_f   = hv && fx[head] && recov;
  assign take_x   = hv && !fx[head] && xx[head];
  assign ret      = hv && !fx[head] && !xx[head] && dn[head];
  assign take_p   = ret && pe[head];
  assign take_any = take_f || take_x || take_p;
  assign imp      = take_x && xc[head][1] && dac[head];
  assign cause_n  = take_f ? 3'b000 :
                    take_x ? (imp ? 3'b010 : {1'b1, xc[head]}) : 3'b001;

  assign redir_ok = redirect_valid && vld[redirect_idx];
  assign off_r    = redirect_idx - head;
  assign base_cnt = redir_ok ? ({1'b0, off_r} + 1'b1) : cnt;
  assign alloc_ok = alloc_valid && !win_full && !redir_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= '0;
      vld  <= '0; fx <= '0; xx <= '0; dn <= '0; pe <= '0; dac <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        xc[i]  <= '0;
        pcs[i] <= '0;
      end
      take_valid   <= 1'b0;
      take_cause   <= '0;
      take_pc      <= '0;
      take_imp     <= 1'b0;
      retire_valid <= 1'b0;
      retire_pc    <= '0;
    end else begin
      take_valid   <= take_any;
      take_cause   <= take_any ? cause_n : 3'b000;
      take_pc      <= take_p ? pcs[head] + PCW'(4) : pcs[head];
      take_imp     <= imp;
      retire_valid <= ret;
      retire_pc    <= pcs[head];
      if (take_any) begin
        head <= '0;
        cnt  <= '0;
        vld  <= '0;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (exec_valid && vld[i] && exec_idx == IDXW'(i)) begin
            xx[i]  <= 1'b1;
            xc[i]  <= exec_class;
            dac[i] <= exec_dac;
          end
          if (cmpl_valid && vld[i] && cmpl_idx == IDXW'(i)) begin
            dn[i] <= 1'b1;
            pe[i] <= |(cmpl_post & dbg_en);
          end
          if (redir_ok && (IDXW'(IDXW'(i) - head) > off_r)) vld[i] <= 1'b0;
          if (ret && head == IDXW'(i)) vld[i] <= 1'b0;
          if (alloc_ok && tail_slot == IDXW'(i)) begin
            vld[i] <= 1'b1;
            pcs[i] <= alloc_pc;
            fx[i]  <= alloc_fexc;
            xx[i]  <= 1'b0;
            dn[i]  <= 1'b0;
            pe[i]  <= 1'b0;
            dac[i] <= 1'b0;
          end
        end
        head <= head + IDXW'(ret);
        cnt  <= base_cnt - (IDXW+1)'(ret) + (IDXW+1)'(alloc_ok);
      end
    end
  end
endmodule

module exc_commit_tracker_chk #(
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            recov,
  input logic [IDXW-1:0] tail_slot,
  input logic            win_full,
  input logic            take_valid,
  input logic [2:0]      take_cause,
  input logic            take_imp,
  input logic            retire_valid
);
  assert_fetch_needs_recov_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_cause == 3'b000) |-> $past(recov));
  assert_exec_not_retired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_cause[2]) |-> !retire_valid);
  assert_post_with_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_cause == 3'b001) |-> retire_valid);
  assert_imp_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_imp |-> (take_valid && take_cause == 3'b010));
  assert_flush_on_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (tail_slot == '0 && !win_full));
endmodule

bind exc_commit_tracker exc_commit_tracker_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .recov(recov), .tail_slot(tail_slot),
  .win_full(win_full), .take_valid(take_valid), .take_cause(take_cause),
  .take_imp(take_imp), .retire_valid(retire_valid)
);

// File: tb/exc_commit_tracker_test.sv
`timescale 1ns/1ps
module exc_commit_tracker_test;
  localparam int PCW = 32;
  localparam int IDXW = 2;

  logic clk = 0, rst_n = 0, recov = 0;
  logic [1:0] dbg_en = 0;
  logic alloc_valid = 0, alloc_fexc = 0;
  logic [PCW-1:0] alloc_pc = 0;
  logic exec_valid = 0, exec_dac = 0;
  logic [IDXW-1:0] exec_idx = 0;
  logic [1:0] exec_class = 0;
  logic cmpl_valid = 0;
  logic [IDXW-1:0] cmpl_idx = 0;
  logic [1:0] cmpl_post = 0;
  logic redirect_valid = 0;
  logic [IDXW-1:0] redirect_idx = 0;
  logic [IDXW-1:0] tail_slot;
  logic win_full, take_valid, take_imp, retire_valid;
  logic [2:0] take_cause;
  logic [PCW-1:0] take_pc, retire_pc;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exc_commit_tracker uut (.*);

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [PCW-1:0] pc, input logic f, output logic [IDXW-1:0] s);
    s = tail_slot; alloc_valid = 1; alloc_pc = pc; alloc_fexc = f;
    tick(); alloc_valid = 0; alloc_fexc = 0;
  endtask
  task automatic do_exec(input logic [IDXW-1:0] s, input logic [1:0] c, input logic d);
    exec_valid = 1; exec_idx = s; exec_class = c; exec_dac = d;
    tick(); exec_valid = 0; exec_dac = 0;
  endtask
  task automatic do_cmpl(input logic [IDXW-1:0] s, input logic [1:0] p);
    cmpl_valid = 1; cmpl_idx = s; cmpl_post = p;
    tick(); cmpl_valid = 0; cmpl_post = 0;
  endtask
  task automatic do_redir(input logic [IDXW-1:0] s);
    redirect_valid = 1; redirect_idx = s;
    tick(); redirect_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1", "take_valid", take_valid, 0);
    chk("R1", "take_imp", take_imp, 0);
    chk("R1", "retire_valid", retire_valid, 0);
    chk("R1", "win_full", win_full, 0);
    chk("R1", "tail_slot", tail_slot, 0);
  endtask

  task automatic t_order();
    logic [IDXW-1:0] a, b;
    do_alloc(32'h100, 0, a);
    do_alloc(32'h104, 0, b);
    do_cmpl(b, 0);
    tick();
    chk("R2", "younger held", retire_valid, 0);
    do_cmpl(a, 0);
    chk("R2", "one cycle latency", retire_valid, 0);
    tick();
    chk("R2", "first retire", retire_valid, 1);
    chk("R2", "first pc", retire_pc, 32'h100);
    tick();
    chk("R2", "second retire", retire_valid, 1);
    chk("R2", "second pc", retire_pc, 32'h104);
    tick();
    chk("R2", "empty", retire_valid, 0);
  endtask

  task automatic t_fetch();
    logic [IDXW-1:0] a;
    recov = 0;
    do_alloc(32'h200, 1, a);
    tick(); tick();
    chk("R3", "held while unrecoverable", take_valid, 0);
    recov = 1;
    tick();
    chk("R3", "take", take_valid, 1);
    chk("R3", "cause", take_cause, 3'b000);
    chk("R3", "pc", take_pc, 32'h200);
    chk("R3", "no retire", retire_valid, 0);
    chk("R10", "tail after flush", tail_slot, 0);
    tick();
    chk("R3", "single take", take_valid, 0);
  endtask

  task automatic t_redirect();
    logic [IDXW-1:0] a, b;
    do_alloc(32'h300, 0, a);
    do_alloc(32'h304, 1, b);
    do_redir(a);
    chk("R4", "no take on redirect", take_valid, 0);
    chk("R4", "tail", tail_slot, IDXW'(a + 1));
    do_cmpl(a, 0);
    tick();
    chk("R4", "older retires", retire_pc, 32'h300);
    chk("R4", "no take", take_valid, 0);
    tick();
    chk("R4", "dropped fetch mark", take_valid, 0);
    chk("R4", "nothing retires", retire_valid, 0);
  endtask

  task automatic t_exec();
    logic [IDXW-1:0] a, b;
    do_alloc(32'h400, 0, a);
    do_alloc(32'h404, 0, b);
    do_exec(b, 2'd1, 0);
    tick();
    chk("R5", "waits for older", take_valid, 0);
    do_cmpl(a, 0);
    tick();
    chk("R5", "older retires first", retire_pc, 32'h400);
    chk("R5", "not yet taken", take_valid, 0);
    tick();
    chk("R5", "take", take_valid, 1);
    chk("R5", "cause", take_cause, 3'b101);
    chk("R5", "pc", take_pc, 32'h404);
    chk("R5", "not completed", retire_valid, 0);
  endtask

  task automatic t_older_wins();
    logic [IDXW-1:0] a, b;
    dbg_en = 2'b11;
    do_alloc(32'h500, 0, a);
    do_alloc(32'h504, 0, b);
    do_exec(b, 2'd0, 0);
    do_cmpl(a, 2'b10);
    tick();
    chk("R7", "post take", take_valid, 1);
    chk("R7", "cause", take_cause, 3'b001);
    chk("R7", "next pc", take_pc, 32'h504);
    chk("R7", "retire with take", retire_pc, 32'h500);
    chk("R10", "tail after flush", tail_slot, 0);
    tick();
    chk("R6", "younger fault discarded", take_valid, 0);
  endtask

  task automatic t_disabled();
    logic [IDXW-1:0] a;
    dbg_en = 2'b10;
    do_alloc(32'h600, 0, a);
    do_cmpl(a, 2'b01);
    tick();
    chk("R7", "retires", retire_valid, 1);
    chk("R7", "disabled event", take_valid, 0);
  endtask

  task automatic t_post_dropped();
    logic [IDXW-1:0] a;
    dbg_en = 2'b11;
    do_alloc(32'h700, 0, a);
    do_exec(a, 2'd0, 0);
    do_cmpl(a, 2'b01);
    chk("R8", "take", take_valid, 1);
    chk("R8", "exec cause wins", take_cause, 3'b100);
    chk("R8", "pc", take_pc, 32'h700);
    tick();
    chk("R8", "no second take", take_valid, 0);
  endtask

  task automatic t_imprecise();
    logic [IDXW-1:0] a;
    do_alloc(32'h800, 0, a);
    do_exec(a, 2'd2, 1);
    tick();
    chk("R9", "cause", take_cause, 3'b010);
    chk("R9", "imprecise bit", take_imp, 1);
    chk("R9", "pc", take_pc, 32'h800);
    do_alloc(32'h810, 0, a);
    do_exec(a, 2'd3, 0);
    tick();
    chk("R9", "plain data storage", take_cause, 3'b111);
    chk("R9", "precise", take_imp, 0);
  endtask

  task automatic t_full();
    logic [IDXW-1:0] s [4];
    logic [IDXW-1:0] x;
    int nret = 0, ntake = 0;
    for (int i = 0; i < 4; i++) do_alloc(32'h900 + 4 * i, 0, s[i]);
    chk("R11", "full", win_full, 1);
    do_alloc(32'h9F0, 1, x);
    chk("R11", "still full", win_full, 1);
    chk("R11", "no take", take_valid, 0);
    for (int i = 0; i < 4; i++) begin
      do_cmpl(s[i], 0);
      if (retire_valid) begin
        chk("R11", "retire order", retire_pc, 32'h900 + 4 * nret);
        nret++;
      end
      ntake += int'(take_valid);
    end
    for (int i = 0; i < 4; i++) begin
      tick();
      if (retire_valid) begin
        chk("R11", "retire order", retire_pc, 32'h900 + 4 * nret);
        nret++;
      end
      ntake += int'(take_valid);
    end
    chk("R11", "retire count", nret, 4);
    chk("R11", "extra entry ignored", ntake, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_order();
    t_fetch();
    t_redirect();
    t_exec();
    t_older_wins();
    t_disabled();
    t_post_dropped();
    t_imprecise();
    t_full();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule